// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Instruction Decode

This block is the execute-stage arithmetic unit of a small 32-bit load/store datapath. It is purely combinational. The caller presents the 6-bit primary opcode and the 6-bit function field of the current instruction, together with the two register operands and the 16-bit immediate. The block decodes which operation is wanted. It picks the second operand from the register value or from the immediate. The immediate is widened with sign copies or with zeros, or it is moved to the upper half. The block then produces a 32-bit result and four flags.

One adder does all additive work. Subtraction, both set-less-than forms and equality testing drive that adder with the second operand inverted and a carry-in of 1. The signed overflow flag is raised only by the instructions that trap on overflow. The unsigned variants and the compare instructions never raise it. An opcode/function pair the block does not recognise gives a zero result and raises an illegal-operation flag.

Top module: `alu_core`

## Requirements
- R1: Additive instructions return the low 32 bits of the first operand plus the second operand. These are function 100000 and 100001 under opcode 000000, and opcodes 001000 and 001001. Carry out is bit 32 of that sum.
- R2: Subtract instructions (function 100010 and 100011 under opcode 000000) return A + ~B + 1 modulo 2^32. Carry out is 1 exactly when A >= B as unsigned numbers.
- R3: The overflow output rises only for function 100000, function 100010 and opcode 001000. For addition it rises when both operands have the same sign and the result sign differs. For subtraction it rises when the operand signs differ and the result sign differs from A. All other instructions hold it at 0.
- R4: Signed set-less-than (function 101010, opcode 001010) returns 1 in bit 0 and zeros in bits 31..1 when A < B as two's-complement numbers. This holds even when A - B overflows. Otherwise it returns 0.
- R5: Unsigned set-less-than (function 101011, opcode 001011) returns 1 in bit 0 when A < B as unsigned numbers, otherwise 0. Carry out for both compare forms is the subtraction carry.
- R6: Function codes 100100, 100101, 100110 and 100111 return bitwise AND, OR, XOR and NOR of the two register operands, with carry out 0.
- R7: Opcodes 001000, 001001, 001010 and 001011 sign-extend the immediate (bit 15 copied into bits 31..16). Opcodes 001100, 001101 and 001110 zero-extend it and return AND, OR and XOR with A.
- R8: Opcode 001111 returns the immediate in bits 31..16 and zeros in bits 15..0, with carry out 0.
- R9: The zero output is 1 exactly when all 32 result bits are 0. Subtracting equal operands therefore gives zero 1 and carry 1.
- R10: An opcode/function pair outside the sets above drives the result to 0, carry and overflow to 0, and the illegal output to 1. Every recognised pair drives the illegal output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field, used when opcode is 000000 |
| rs_val_i | input | 32 | First operand A |
| rt_val_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | All result bits zero |
| carry_o | output | 1 | Adder carry out for additive and compare operations |
| ovf_o | output | 1 | Signed overflow for trapping instructions |
| illegal_o | output | 1 | Unrecognised opcode/function pair |

## Verification
The additive and compare paths are driven with operand pairs at the signed boundaries, such as 0x7FFFFFFF + 1, 0x80000000 - 1 and mixed-sign sums. These pairs separate a real overflow from a plain carry. They also separate the signed compare from the unsigned one, and show whether the signed compare survives an overflowing subtraction. The same pairs go through the trapping and non-trapping encodings, which shows whether overflow is qualified by the instruction. Immediates with bit 15 set tell sign-extension apart from zero-extension. Equal operands under subtraction, and unused opcode and function codes, cover the zero flag and the illegal path.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;

  localparam logic [FN_W-1:0] FN_ADD  = 6'b100000;
  localparam logic [FN_W-1:0] FN_ADDU = 6'b100001;
  localparam logic [FN_W-1:0] FN_SUB  = 6'b100010;
  localparam logic [FN_W-1:0] FN_SUBU = 6'b100011;
  localparam logic [FN_W-1:0] FN_AND  = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR   = 6'b100101;
  localparam logic [FN_W-1:0] FN_XOR  = 6'b100110;
  localparam logic [FN_W-1:0] FN_NOR  = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT  = 6'b101010;
  localparam logic [FN_W-1:0] FN_SLTU = 6'b101011;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_PASS_B, OP_NONE
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT, SRC_UPPER
  } src_sel_e;

  typedef struct packed {
    alu_op_e  op;
    src_sel_e src;
    logic     trap;
    logic     illegal;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output alu_ctrl_t        ctrl_o
);

  always_comb begin
    ctrl_o.op      = OP_NONE;
    ctrl_o.src     = SRC_REG;
    ctrl_o.trap    = 1'b0;
    ctrl_o.illegal = 1'b0;
    unique case (opcode_i)
      OPC_RTYPE: begin
        unique case (funct_i)
          FN_ADD:  begin ctrl_o.op = OP_ADD; ctrl_o.trap = 1'b1; end
          FN_ADDU: ctrl_o.op = OP_ADD;
          FN_SUB:  begin ctrl_o.op = OP_SUB; ctrl_o.trap = 1'b1; end
          FN_SUBU: ctrl_o.op = OP_SUB;
          FN_AND:  ctrl_o.op = OP_AND;
          FN_OR:   ctrl_o.op = OP_OR;
          FN_XOR:  ctrl_o.op = OP_XOR;
          FN_NOR:  ctrl_o.op = OP_NOR;
          FN_SLT:  ctrl_o.op = OP_SLT;
          FN_SLTU: ctrl_o.op = OP_SLTU;
          default: ctrl_o.illegal = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctrl_o.op = OP_ADD;  ctrl_o.src = SRC_SEXT; ctrl_o.trap = 1'b1; end
      OPC_ADDIU: begin ctrl_o.op = OP_ADD;  ctrl_o.src = SRC_SEXT; end
      OPC_SLTI:  begin ctrl_o.op = OP_SLT;  ctrl_o.src = SRC_SEXT; end
      OPC_SLTIU: begin ctrl_o.op = OP_SLTU; ctrl_o.src = SRC_SEXT; end
      OPC_ANDI:  begin ctrl_o.op = OP_AND;  ctrl_o.src = SRC_ZEXT; end
      OPC_ORI:   begin ctrl_o.op = OP_OR;   ctrl_o.src = SRC_ZEXT; end
      OPC_XORI:  begin ctrl_o.op = OP_XOR;  ctrl_o.src = SRC_ZEXT; end
      OPC_LUI:   begin ctrl_o.op = OP_PASS_B; ctrl_o.src = SRC_UPPER; end
      default:   ctrl_o.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_operand.sv
module alu_operand
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  src_sel_e         src_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0] b_o
);

  localparam int EXT_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] sext, zext, upper;

  assign sext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign zext  = {{EXT_W{1'b0}}, imm_i};
  assign upper = {imm_i, {EXT_W{1'b0}}};

  always_comb begin
    unique case (src_i)
      SRC_SEXT:  b_o = sext;
      SRC_ZEXT:  b_o = zext;
      SRC_UPPER: b_o = upper;
      default:   b_o = reg_i;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NOR:  y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  input  logic [WIDTH-1:0] rs_val_i,
  input  logic [WIDTH-1:0] rt_val_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             illegal_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] b_op, sum, logic_y;
  logic             cout, ovf_raw, do_sub, uses_adder, lt_signed, lt_unsigned;

  alu_decode u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .ctrl_o   (ctrl)
  );

  alu_operand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opnd (
    .src_i (ctrl.src),
    .reg_i (rt_val_i),
    .imm_i (imm_i),
    .b_o   (b_op)
  );

  assign do_sub     = (ctrl.op == OP_SUB) || (ctrl.op == OP_SLT) || (ctrl.op == OP_SLTU);
  assign uses_adder = do_sub || (ctrl.op == OP_ADD);

  alu_addsub #(.WIDTH(WIDTH)) u_add (
    .a_i    (rs_val_i),
    .b_i    (b_op),
    .sub_i  (do_sub),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf_raw)
  );

  alu_logic #(.WIDTH(WIDTH)) u_log (
    .op_i (ctrl.op),
    .a_i  (rs_val_i),
    .b_i  (b_op),
    .y_o  (logic_y)
  );

  assign lt_signed   = sum[MSB] ^ ovf_raw;
  assign lt_unsigned = ~cout;

  always_comb begin
    unique case (ctrl.op)
      OP_ADD, OP_SUB:                 result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:  result_o = logic_y;
      OP_SLT:    result_o = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:   result_o = {{(WIDTH-1){1'b0}}, lt_unsigned};
      OP_PASS_B: result_o = b_op;
      default:   result_o = '0;
    endcase
  end

  assign zero_o    = ~|result_o;
  assign carry_o   = uses_adder & cout;
  assign ovf_o     = ctrl.trap & ovf_raw;
  assign illegal_o = ctrl.illegal;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [OPC_W-1:0] opcode_i,
  input logic [FN_W-1:0]  funct_i,
  input logic [WIDTH-1:0] rs_val_i,
  input logic [WIDTH-1:0] rt_val_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             illegal_o
);

  logic is_r, nontrap, is_cmp, is_sub;

  assign is_r    = (opcode_i == OPC_RTYPE);
  assign nontrap = (is_r && (funct_i == FN_ADDU || funct_i == FN_SUBU ||
                             funct_i == FN_SLTU || funct_i == FN_SLT)) ||
                   opcode_i == OPC_ADDIU || opcode_i == OPC_SLTIU || opcode_i == OPC_SLTI;
  assign is_cmp  = (is_r && (funct_i == FN_SLT || funct_i == FN_SLTU)) ||
                   opcode_i == OPC_SLTI || opcode_i == OPC_SLTIU;
  assign is_sub  = is_r && (funct_i == FN_SUB || funct_i == FN_SUBU);

  always_comb begin
    // R9: zero flag tracks the result
    p_zero_flag_r9: assert (zero_o == (result_o == '0));
    // R3: non-trapping variants never flag overflow
    if (nontrap) p_no_overflow_r3: assert (!ovf_o);
    // R4 / R5: compare results occupy only bit 0
    if (is_cmp) p_cmp_shape_r4: assert (result_o[WIDTH-1:1] == '0);
    // R8: upper-immediate placement
    if (opcode_i == OPC_LUI)
      p_upper_imm_r8: assert (result_o == {imm_i, {(WIDTH-IMM_W){1'b0}}} && !carry_o);
    // R9 / R2: equal operands subtract to zero without borrow
    if (is_sub && rs_val_i == rt_val_i)
      p_sub_equal_r9: assert (zero_o && carry_o && !ovf_o);
    // R10: illegal pairs stay quiet
    if (illegal_o)
      p_illegal_quiet_r10: assert (result_o == '0 && !carry_o && !ovf_o);
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
  .opcode_i  (opcode_i),
  .funct_i   (funct_i),
  .rs_val_i  (rs_val_i),
  .rt_val_i  (rt_val_i),
  .imm_i     (imm_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;

  logic        clk;
  logic [5:0]  opcode, funct;
  logic [31:0] rs, rt;
  logic [15:0] imm;
  logic [31:0] result;
  logic        zero, carry, ovf, illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [31:0] res;
    logic        z, c, v, ill;
    string       tag;
  } exp_t;

  exp_t sb[$];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  alu_core u0 (
    .opcode_i (opcode), .funct_i (funct), .rs_val_i (rs), .rt_val_i (rt),
    .imm_i (imm), .result_o (result), .zero_o (zero), .carry_o (carry),
    .ovf_o (ovf), .illegal_o (illegal)
  );

  function automatic exp_t model(input logic [5:0] op, input logic [5:0] fn,
                                 input logic [31:0] a, input logic [31:0] r,
                                 input logic [15:0] im, input string tag);
    exp_t e;
    logic [31:0] b;
    logic [32:0] s;
    int kind; // 0 add 1 sub 2 and 3 or 4 xor 5 nor 6 slt 7 sltu 8 lui 9 bad
    bit trap;
    e.tag = tag; trap = 0; kind = 9; b = r;
    if (op == 6'b000000) begin
      case (fn)
        6'b100000: begin kind = 0; trap = 1; end
        6'b100001: kind = 0;
        6'b100010: begin kind = 1; trap = 1; end
        6'b100011: kind = 1;
        6'b100100: kind = 2;
        6'b100101: kind = 3;
        6'b100110: kind = 4;
        6'b100111: kind = 5;
        6'b101010: kind = 6;
        6'b101011: kind = 7;
        default:   kind = 9;
      endcase
    end else begin
      case (op)
        6'b001000: begin kind = 0; trap = 1; b = {{16{im[15]}}, im}; end
        6'b001001: begin kind = 0; b = {{16{im[15]}}, im}; end
        6'b001010: begin kind = 6; b = {{16{im[15]}}, im}; end
        6'b001011: begin kind = 7; b = {{16{im[15]}}, im}; end
        6'b001100: begin kind = 2; b = {16'h0, im}; end
        6'b001101: begin kind = 3; b = {16'h0, im}; end
        6'b001110: begin kind = 4; b = {16'h0, im}; end
        6'b001111: kind = 8;
        default:   kind = 9;
      endcase
    end
    e.c = 0; e.v = 0; e.ill = 0; e.res = 32'h0;
    case (kind)
      0: begin
        s = {1'b0, a} + {1'b0, b};
        e.res = s[31:0]; e.c = s[32];
        e.v = trap && (a[31] == b[31]) && (s[31] != a[31]);
      end
      1: begin
        e.res = a - b; e.c = (a >= b);
        e.v = trap && (a[31] != b[31]) && (e.res[31] != a[31]);
      end
      2: e.res = a & b;
      3: e.res = a | b;
      4: e.res = a ^ b;
      5: e.res = ~(a | b);
      6: begin e.res = {31'h0, ($signed(a) < $signed(b))}; e.c = (a >= b); end
      7: begin e.res = {31'h0, (a < b)}; e.c = (a >= b); end
      8: e.res = {im, 16'h0};
      default: e.ill = 1;
    endcase
    e.z = (e.res == 32'h0);
    return e;
  endfunction

  task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] r,
                       input logic [15:0] im, input string tag);
    @(posedge clk);
    #1;
    opcode = op; funct = fn; rs = a; rt = r; imm = im;
    sb.push_back(model(op, fn, a, r, im, tag));
  endtask

  // Monitor: compare at the falling edge, after inputs have settled
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (result !== e.res || zero !== e.z || carry !== e.c ||
            ovf !== e.v || illegal !== e.ill) begin
          n_fail++;
          $display("FAIL %s: got res=%h z=%b c=%b v=%b ill=%b exp res=%h z=%b c=%b v=%b ill=%b",
                   e.tag, result, zero, carry, ovf, illegal,
                   e.res, e.z, e.c, e.v, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    opcode = 6'h3f; funct = 6'h00; rs = 32'h0; rt = 32'h0; imm = 16'h0;
    // R10 idle state: unused opcode
    drive(6'b111111, 6'b000000, 32'h0, 32'h0, 16'h0, "R10 idle");
    // R1 addition
    drive(6'b000000, 6'b100000, 32'd4, 32'd4, 16'h0, "R1 add");
    drive(6'b000000, 6'b100001, 32'hFFFFFFFF, 32'd1, 16'h0, "R1 addu carry");
    drive(6'b001001, 6'b000000, 32'd10, 32'h0, 16'hFFFD, "R1 addiu neg imm");
    // R2 subtraction
    drive(6'b000000, 6'b100010, 32'd4, 32'd3, 16'h0, "R2 sub");
    drive(6'b000000, 6'b100011, 32'd3, 32'd4, 16'h0, "R2 subu borrow");
    drive(6'b000000, 6'b100010, 32'h1234, 32'h1234, 16'h0, "R9 sub equal");
    // R3 overflow qualification
    drive(6'b000000, 6'b100000, 32'h7FFFFFFF, 32'd1, 16'h0, "R3 add pos ovf");
    drive(6'b000000, 6'b100000, 32'h80000000, 32'hFFFFFFFF, 16'h0, "R3 add neg ovf");
    drive(6'b000000, 6'b100001, 32'h7FFFFFFF, 32'd1, 16'h0, "R3 addu no ovf");
    drive(6'b000000, 6'b100000, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, "R3 mixed add");
    drive(6'b000000, 6'b100010, 32'h80000000, 32'd1, 16'h0, "R3 sub ovf");
    drive(6'b000000, 6'b100010, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, "R3 sub ovf2");
    drive(6'b000000, 6'b100011, 32'h80000000, 32'd1, 16'h0, "R3 subu no ovf");
    drive(6'b000000, 6'b100010, 32'hFFFFFFF0, 32'hFFFFFFFF, 16'h0, "R3 same sign sub");
    drive(6'b001000, 6'b000000, 32'h7FFFFFFF, 32'h0, 16'h0001, "R3 addi ovf");
    drive(6'b001001, 6'b000000, 32'h7FFFFFFF, 32'h0, 16'h0001, "R3 addiu no ovf");
    // R4 signed compare
    drive(6'b000000, 6'b101010, 32'h80000000, 32'd1, 16'h0, "R4 slt ovf case");
    drive(6'b000000, 6'b101010, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, "R4 slt ovf case2");
    drive(6'b000000, 6'b101010, 32'd5, 32'd5, 16'h0, "R4 slt equal");
    drive(6'b001010, 6'b000000, 32'hFFFFFFFE, 32'h0, 16'hFFFF, "R4 slti neg");
    // R5 unsigned compare
    drive(6'b000000, 6'b101011, 32'h80000000, 32'd1, 16'h0, "R5 sltu");
    drive(6'b000000, 6'b101011, 32'd1, 32'h80000000, 16'h0, "R5 sltu lt");
    drive(6'b001011, 6'b000000, 32'h00001000, 32'h0, 16'h8000, "R5 sltiu sext");
    // R6 logic
    drive(6'b000000, 6'b100100, 32'hF0F0A5A5, 32'h0FF0FF00, 16'h0, "R6 and");
    drive(6'b000000, 6'b100101, 32'hF0F0A5A5, 32'h0FF0FF00, 16'h0, "R6 or");
    drive(6'b000000, 6'b100110, 32'hF0F0A5A5, 32'h0FF0FF00, 16'h0, "R6 xor");
    drive(6'b000000, 6'b100111, 32'hF0F0A5A5, 32'h0FF0FF00, 16'h0, "R6 nor");
    drive(6'b000000, 6'b100111, 32'hFFFFFFFF, 32'h0, 16'h0, "R9 nor zero");
    // R7 immediate extension
    drive(6'b001100, 6'b000000, 32'hFFFFFFFF, 32'h0, 16'h8001, "R7 andi zext");
    drive(6'b001101, 6'b000000, 32'h12340000, 32'h0, 16'hF00F, "R7 ori zext");
    drive(6'b001110, 6'b000000, 32'hFFFF0000, 32'h0, 16'hFFFF, "R7 xori zext");
    drive(6'b001000, 6'b000000, 32'd100, 32'h0, 16'hFF9C, "R7 addi sext");
    // R8 upper immediate
    drive(6'b001111, 6'b000000, 32'hDEADBEEF, 32'h0, 16'h1234, "R8 lui");
    drive(6'b001111, 6'b000000, 32'h0, 32'h0, 16'h0, "R8 lui zero");
    // R10 illegal pairs
    drive(6'b000000, 6'b000101, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, "R10 bad funct");
    drive(6'b000000, 6'b101000, 32'h7FFFFFFF, 32'd1, 16'h0, "R10 bad funct2");
    drive(6'b000010, 6'b100000, 32'h7FFFFFFF, 32'd1, 16'h0, "R10 bad opcode");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule